// File: doc/BRIEF.md
# Interrupt Pending and Take Unit

This unit holds an eight-bit register of pending interrupt levels for a processor core and decides, every cycle, whether the core should take an interrupt. Software or peripheral logic raises one level with a post strobe, lowers one level with a clear strobe, or empties the whole field with a clear-all strobe. Each strobe carries a level number.

The unit also watches the core's free-running count against a compare value. When the two are equal and the count is nonzero, a timer match raises the level chosen by a three-bit timer index. The match shows on the pending outputs in the same cycle and is held in the register from the next edge on.

The take decision uses a status word: a global enable, an error-level flag, an exception-level flag and an eight-bit mask. The core takes an interrupt only when the enable is set, both level flags are clear, the mask is nonzero and at least one level is pending. The mask and the pending field are not compared bit by bit. A level number outside 0 to 7 changes nothing and raises a one-cycle error flag.

Top module: `irq_pend_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the pending register and `bad_num_o` are cleared. With no timer match, `pend_o` then reads 8'h00 and `take_o` reads 0.
- R2: A post strobe with level n in 0..7 sets bit n of `pend_o` from the next edge on and leaves the other bits unchanged.
- R3: A clear strobe with level n in 0..7 clears bit n of the pending register at the next edge and leaves the other bits unchanged.
- R4: When post and clear name the same level in the same cycle, that bit ends up cleared.
- R5: A clear-all strobe makes the pending register zero at the next edge, whatever post, clear or timer match occurs in the same cycle.
- R6: When `compare_i` equals `count_i` and `count_i` is nonzero, bit `tmr_idx_i` of `pend_o` reads 1 in the same cycle. Unless cleared, it is stored at the next edge and stays set after the match ends.
- R7: When `count_i` and `compare_i` are both zero, no timer match occurs.
- R8: `pend_any_o` is 1 exactly when `pend_o` is nonzero.
- R9: `take_o` is 1 only when `glb_en_i` is 1, `err_lvl_i` is 0 and `exc_lvl_i` is 0. Any one of these three failing forces `take_o` to 0.
- R10: The mask test passes whenever `mask_i` and `pend_o` are both nonzero, even when they share no set bit. An all-zero mask forces `take_o` to 0.
- R11: A post or clear strobe with a level number from 8 to 15 leaves the pending register unchanged. It drives `bad_num_o` high in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| post_i | input | 1 | Post strobe |
| post_num_i | input | 4 | Level to raise |
| clr_i | input | 1 | Clear strobe |
| clr_num_i | input | 4 | Level to lower |
| clr_all_i | input | 1 | Clear every pending level |
| count_i | input | 32 | Core count value |
| compare_i | input | 32 | Timer compare value |
| tmr_idx_i | input | 3 | Level raised by a timer match |
| glb_en_i | input | 1 | Global interrupt enable |
| err_lvl_i | input | 1 | Error level flag |
| exc_lvl_i | input | 1 | Exception level flag |
| mask_i | input | 8 | Interrupt mask |
| pend_o | output | 8 | Pending levels, timer match included |
| pend_any_o | output | 1 | Some level is pending |
| take_o | output | 1 | Core should take an interrupt |
| bad_num_o | output | 1 | Previous cycle had an out-of-range level |

## Verification
The assertions check on every cycle that posts and clears act on their named bits, that clear-all empties the register, that a live timer match shows its indexed bit, that the any-pending flag matches the field, and that a take never happens with a level flag set, the enable low or the mask empty. Only the bench's scenarios can show that other bits are left alone across a sequence of requests. They also show that clear beats post on one level, that a stored timer bit stays after the match ends, that a zero count never matches, and that a disjoint mask still lets an interrupt through.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
    localparam int LEVELS = 8;
    localparam int IDX_W  = $clog2(LEVELS);
    localparam int NUM_W  = IDX_W + 1;
    typedef logic [LEVELS-1:0] pend_t;
endpackage

// File: rtl/irq_req_decode.sv
module irq_req_decode
    import irq_pend_pkg::*;
(
    input  logic             strobe,
    input  logic [NUM_W-1:0] num,
    output pend_t            vec,
    output logic             bad
);
    // Turn a strobe and level number into a one-hot vector.
    // A number outside the level range gives no bit and flags an error.
    for (genvar i = 0; i < LEVELS; i++) begin : g_bit
        assign vec[i] = strobe && (num == NUM_W'(i));
    end
    assign bad = strobe && (num >= NUM_W'(LEVELS));
endmodule

// File: rtl/irq_timer_match.sv
module irq_timer_match
    import irq_pend_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] compare,
    input  logic [IDX_W-1:0] idx,
    output logic             hit,
    output pend_t            vec
);
    // A zero count never matches.
    assign hit = (count == compare) && (count != '0);
    for (genvar i = 0; i < LEVELS; i++) begin : g_bit
        assign vec[i] = hit && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/irq_take_gate.sv
module irq_take_gate
    import irq_pend_pkg::*;
(
    input  logic  glb_en,
    input  logic  err_lvl,
    input  logic  exc_lvl,
    input  pend_t mask,
    input  pend_t pend,
    output logic  take
);
    logic level_ok;
    // The mask only needs to be nonzero; it is not ANDed with the pending field.
    assign level_ok = glb_en && !err_lvl && !exc_lvl;
    assign take     = level_ok && (|mask) && (|pend);
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit
    import irq_pend_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             post_i,
    input  logic [3:0]       post_num_i,
    input  logic             clr_i,
    input  logic [3:0]       clr_num_i,
    input  logic             clr_all_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] compare_i,
    input  logic [2:0]       tmr_idx_i,
    input  logic             glb_en_i,
    input  logic             err_lvl_i,
    input  logic             exc_lvl_i,
    input  logic [7:0]       mask_i,
    output logic [7:0]       pend_o,
    output logic             pend_any_o,
    output logic             take_o,
    output logic             bad_num_o
);
    pend_t post_vec, clr_vec, tmr_vec, pend_q, pend_d, pend_view;
    logic  post_bad, clr_bad, tmr_hit, bad_q;

    irq_req_decode u_post (
        .strobe (post_i),
        .num    (post_num_i),
        .vec    (post_vec),
        .bad    (post_bad)
    );

    irq_req_decode u_clr (
        .strobe (clr_i),
        .num    (clr_num_i),
        .vec    (clr_vec),
        .bad    (clr_bad)
    );

    irq_timer_match #(.CNT_W(CNT_W)) u_tmr (
        .count   (count_i),
        .compare (compare_i),
        .idx     (tmr_idx_i),
        .hit     (tmr_hit),
        .vec     (tmr_vec)
    );

    // Clear-all beats everything; a single clear beats post and timer.
    always_comb begin
        if (clr_all_i) begin
            pend_d = '0;
        end else begin
            pend_d = (pend_q | post_vec | tmr_vec) & ~clr_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            bad_q  <= post_bad | clr_bad;
        end
    end

    // A live timer match is folded into what the core sees.
    assign pend_view = pend_q | tmr_vec;

    irq_take_gate u_gate (
        .glb_en  (glb_en_i),
        .err_lvl (err_lvl_i),
        .exc_lvl (exc_lvl_i),
        .mask    (mask_i),
        .pend    (pend_view),
        .take    (take_o)
    );

    assign pend_o     = pend_view;
    assign pend_any_o = |pend_view;
    assign bad_num_o  = bad_q;
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk
    import irq_pend_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             post_i,
    input logic [3:0]       post_num_i,
    input logic             clr_i,
    input logic [3:0]       clr_num_i,
    input logic             clr_all_i,
    input logic [CNT_W-1:0] count_i,
    input logic [CNT_W-1:0] compare_i,
    input logic [2:0]       tmr_idx_i,
    input logic             glb_en_i,
    input logic             err_lvl_i,
    input logic             exc_lvl_i,
    input logic [7:0]       mask_i,
    input logic [7:0]       pend_o,
    input logic             pend_any_o,
    input logic             take_o,
    input logic             bad_num_o,
    input logic [7:0]       pend_q,
    input logic [7:0]       tmr_vec
);
    AST_POST_SETS: assert property (@(posedge clk) disable iff (rst)
        (post_i && post_num_i < 4'd8 && !clr_all_i && !(clr_i && clr_num_i == post_num_i))
        |=> pend_q[$past(post_num_i[2:0])]); // R2

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (clr_i && clr_num_i < 4'd8) |=> !pend_q[$past(clr_num_i[2:0])]); // R3

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        clr_all_i |=> ((pend_o & ~tmr_vec) == 8'h00)); // R5

    AST_TIMER_SHOWS: assert property (@(posedge clk) disable iff (rst)
        (count_i == compare_i && count_i != '0) |-> pend_o[tmr_idx_i]); // R6

    AST_ANY_FLAG: assert property (@(posedge clk) disable iff (rst)
        pend_any_o == (pend_o != 8'h00)); // R8

    AST_TAKE_LEVELS: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (glb_en_i && !err_lvl_i && !exc_lvl_i)); // R9

    AST_TAKE_MASK: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (mask_i != 8'h00 && pend_o != 8'h00)); // R10

    AST_BAD_FLAG: assert property (@(posedge clk) disable iff (rst)
        ((post_i && post_num_i >= 4'd8) || (clr_i && clr_num_i >= 4'd8)) |=> bad_num_o); // R11

    AST_BAD_UNCHANGED: assert property (@(posedge clk) disable iff (rst)
        (!clr_all_i && !(post_i && post_num_i < 4'd8) && !(clr_i && clr_num_i < 4'd8)
         && tmr_vec == 8'h00) |=> pend_q == $past(pend_q)); // R11
endmodule

bind irq_pend_unit irq_pend_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .post_i     (post_i),
    .post_num_i (post_num_i),
    .clr_i      (clr_i),
    .clr_num_i  (clr_num_i),
    .clr_all_i  (clr_all_i),
    .count_i    (count_i),
    .compare_i  (compare_i),
    .tmr_idx_i  (tmr_idx_i),
    .glb_en_i   (glb_en_i),
    .err_lvl_i  (err_lvl_i),
    .exc_lvl_i  (exc_lvl_i),
    .mask_i     (mask_i),
    .pend_o     (pend_o),
    .pend_any_o (pend_any_o),
    .take_o     (take_o),
    .bad_num_o  (bad_num_o),
    .pend_q     (pend_q),
    .tmr_vec    (tmr_vec)
);

// File: tb/irq_pend_unit_test.sv
module irq_pend_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 19;

    typedef struct packed {
        logic       post;
        logic [3:0] pnum;
        logic       clr;
        logic [3:0] cnum;
        logic       call;
        logic [7:0] cnt;
        logic [7:0] cmp;
        logic [2:0] idx;
        logic       en;
        logic       erl;
        logic       exl;
        logic [7:0] mask;
        logic [7:0] e_pend;
        logic       e_take;
        logic       e_bad;
        logic [3:0] req;
    } vec_t;

    // Fields: post pnum clr cnum call cnt cmp idx en erl exl mask | exp pend take bad | req
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,4'd3,1'b0,4'd0,1'b0,8'd0,8'd0,3'd0,1'b1,1'b0,1'b0,8'hFF,8'h08,1'b1,1'b0,4'd2},  // R2
        '{1'b1,4'd5,1'b0,4'd0,1'b0,8'd0,8'd0,3'd0,1'b1,1'b0,1'b0,8'hFF,8'h28,1'b1,1'b0,4'd2},  // R2
        '{1'b0,4'd0,1'b1,4'd3,1'b0,8'd0,8'd0,3'd0,1'b1,1'b0,1'b0,8'hFF,8'h20,1'b1,1'b0,4'd3},  // R3
        '{1'b1,4'd1,1'b1,4'd1,1'b0,8'd0,8'd0,3'd0,1'b1,1'b0,1'b0,8'hFF,8'h20,1'b1,1'b0,4'd4},  // R4
        '{1'b1,4'd7,1'b1,4'd5,1'b0,8'd0,8'd0,3'd0,1'b1,1'b0,1'b0,8'hFF,8'h80,1'b1,1'b0,4'd3},  // R2 R3
        '{1'b1,4'd9,1'b0,4'd0,1'b0,8'd0,8'd0,3'd0,1'b1,1'b0,1'b0,8'hFF,8'h80,1'b1,1'b1,4'd11}, // R11
        '{1'b0,4'd0,1'b1,4'd12,1'b0,8'd0,8'd0,3'd0,1'b1,1'b0,1'b0,8'hFF,8'h80,1'b1,1'b1,4'd11},// R11
        '{1'b0,4'd0,1'b0,4'd0,1'b0,8'd0,8'd0,3'd0,1'b1,1'b0,1'b0,8'hFF,8'h80,1'b1,1'b0,4'd11}, // R11
        '{1'b1,4'd2,1'b0,4'd0,1'b1,8'd0,8'd0,3'd0,1'b1,1'b0,1'b0,8'hFF,8'h00,1'b0,1'b0,4'd5},  // R5
        '{1'b0,4'd0,1'b0,4'd0,1'b0,8'd5,8'd5,3'd4,1'b1,1'b0,1'b0,8'hFF,8'h10,1'b1,1'b0,4'd6},  // R6
        '{1'b0,4'd0,1'b0,4'd0,1'b0,8'd0,8'd0,3'd2,1'b1,1'b0,1'b0,8'hFF,8'h10,1'b1,1'b0,4'd7},  // R7 R6
        '{1'b0,4'd0,1'b0,4'd0,1'b1,8'd0,8'd0,3'd2,1'b1,1'b0,1'b0,8'hFF,8'h00,1'b0,1'b0,4'd5},  // R5 R7
        '{1'b1,4'd7,1'b0,4'd0,1'b0,8'd0,8'd0,3'd0,1'b1,1'b0,1'b0,8'h01,8'h80,1'b1,1'b0,4'd10}, // R10
        '{1'b0,4'd0,1'b0,4'd0,1'b0,8'd0,8'd0,3'd0,1'b1,1'b0,1'b0,8'h00,8'h80,1'b0,1'b0,4'd10}, // R10
        '{1'b0,4'd0,1'b0,4'd0,1'b0,8'd0,8'd0,3'd0,1'b0,1'b0,1'b0,8'hFF,8'h80,1'b0,1'b0,4'd9},  // R9
        '{1'b0,4'd0,1'b0,4'd0,1'b0,8'd0,8'd0,3'd0,1'b1,1'b1,1'b0,8'hFF,8'h80,1'b0,1'b0,4'd9},  // R9
        '{1'b0,4'd0,1'b0,4'd0,1'b0,8'd0,8'd0,3'd0,1'b1,1'b0,1'b1,8'hFF,8'h80,1'b0,1'b0,4'd9},  // R9
        '{1'b0,4'd0,1'b0,4'd0,1'b0,8'd0,8'd0,3'd0,1'b1,1'b0,1'b0,8'hFF,8'h80,1'b1,1'b0,4'd9},  // R9
        '{1'b0,4'd0,1'b0,4'd0,1'b0,8'd7,8'd8,3'd1,1'b1,1'b0,1'b0,8'hFF,8'h80,1'b1,1'b0,4'd6}   // R6
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        post_i = 1'b0, clr_i = 1'b0, clr_all_i = 1'b0;
    logic [3:0]  post_num_i = '0, clr_num_i = '0;
    logic [31:0] count_i = '0, compare_i = '0;
    logic [2:0]  tmr_idx_i = '0;
    logic        glb_en_i = 1'b1, err_lvl_i = 1'b0, exc_lvl_i = 1'b0;
    logic [7:0]  mask_i = 8'hFF;
    logic [7:0]  pend_o;
    logic        pend_any_o, take_o, bad_num_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pend_unit uut (
        .clk(clk), .rst(rst),
        .post_i(post_i), .post_num_i(post_num_i),
        .clr_i(clr_i), .clr_num_i(clr_num_i), .clr_all_i(clr_all_i),
        .count_i(count_i), .compare_i(compare_i), .tmr_idx_i(tmr_idx_i),
        .glb_en_i(glb_en_i), .err_lvl_i(err_lvl_i), .exc_lvl_i(exc_lvl_i),
        .mask_i(mask_i),
        .pend_o(pend_o), .pend_any_o(pend_any_o), .take_o(take_o), .bad_num_o(bad_num_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        post_i = 1'b0; clr_i = 1'b0; clr_all_i = 1'b0;
        post_num_i = '0; clr_num_i = '0;
        count_i = '0; compare_i = '0; tmr_idx_i = '0;
        glb_en_i = 1'b1; err_lvl_i = 1'b0; exc_lvl_i = 1'b0; mask_i = 8'hFF;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 pend", pend_o, 8'h00);
        chk("R1 bad", {7'b0, bad_num_o}, 8'h00);
        chk("R1 take", {7'b0, take_o}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            post_i = VECS[i].post;  post_num_i = VECS[i].pnum;
            clr_i = VECS[i].clr;    clr_num_i = VECS[i].cnum;
            clr_all_i = VECS[i].call;
            count_i = {24'b0, VECS[i].cnt}; compare_i = {24'b0, VECS[i].cmp};
            tmr_idx_i = VECS[i].idx;
            glb_en_i = VECS[i].en; err_lvl_i = VECS[i].erl; exc_lvl_i = VECS[i].exl;
            mask_i = VECS[i].mask;
            @(posedge clk);
            #1;
            chk($sformatf("R%0d pend v%0d", VECS[i].req, i), pend_o, VECS[i].e_pend);
            chk($sformatf("R%0d take v%0d", VECS[i].req, i), {7'b0, take_o}, {7'b0, VECS[i].e_take});
            chk($sformatf("R%0d bad v%0d", VECS[i].req, i), {7'b0, bad_num_o}, {7'b0, VECS[i].e_bad});
            // R8 any flag follows the field
            chk($sformatf("R8 any v%0d", i), {7'b0, pend_any_o}, {7'b0, (VECS[i].e_pend != 8'h00)});
        end

        // R1 reset mid-run with level 7 pending
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 mid-run reset pend", pend_o, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // R6 match seen in the same cycle, R5 clear-all still empties the register
        count_i = 32'd3; compare_i = 32'd3; tmr_idx_i = 3'd6; clr_all_i = 1'b1;
        #1;
        chk("R6 same-cycle match", pend_o, 8'h40);
        @(posedge clk);
        #1;
        chk("R6 match while held", pend_o, 8'h40);
        @(negedge clk);
        idle();
        #1;
        chk("R5 clear-all beat timer", pend_o, 8'h00);
        chk("R8 any after clear", {7'b0, pend_any_o}, 8'h00);

        // R6 stored bit persists after the match ends
        count_i = 32'h8000_0000; compare_i = 32'h8000_0000; tmr_idx_i = 3'd0;
        @(posedge clk);
        @(negedge clk);
        idle();
        #1;
        chk("R6 stored after match", pend_o, 8'h01);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule